// File: doc/BRIEF.md
# Processor Bus Interface with On-Chip Parallel Port

This block joins a small 8-bit processor core to the system bus. The core makes one request at a time: address, write flag and write data, held until a one-cycle ready pulse. The block latches the request and decodes it. Most addresses become one external bus cycle: a 16-bit address, a read/write flag, a strobe, and an 8-bit data path. The data path is carried as a driven half, its enable and a receive half, which the pad ring merges onto one bidirectional pin set. The two lowest addresses are served on chip by a parallel port. That port is a direction register and an output latch, and no external cycle is started for them.

An address-enable input lets another master take the bus. While it is low, the address pad enables drop, so all sixteen address lines float. A pending core request then waits and does nothing. The port is eight bits inside, but the bit at position five has no pin, so seven lines reach the outside.

The sequencer has five states. IDLE waits for and latches a request. EXT runs one external cycle. PORT serves an on-chip access. DONE presents ready and read data. HOLD parks a request while the bus is floated. The transitions are:
- IDLE→EXT on an external request with the bus enabled.
- IDLE→PORT on a port request with the bus enabled.
- IDLE→HOLD on any request while the bus is floated.
- HOLD→EXT or HOLD→PORT when the enable returns.
- EXT→HOLD and PORT→HOLD if the enable drops during that cycle.
- EXT→DONE and PORT→DONE otherwise.
- DONE→IDLE.

Top module: `bpi_top`

## Requirements
- R1: After reset, every port line is an input (pin_oe all 0), pin_out is all 0, core_ready and bus_strobe are 0. A read of address 0x0001 then returns 0x20, with all pins at 0.
- R2: A request to an address other than 0x0000/0x0001 raises bus_strobe for exactly one cycle, the cycle after the request is accepted. In that cycle bus_addr equals the request address and bus_rw is 1 for a read and 0 for a write. For a write, bus_dout carries the data with bus_dout_oe high. core_ready pulses for one cycle in the next cycle. For a read, core_rdata then holds the bus_din value sampled during the strobe.
- R3: While addr_en is 0, bus_addr_oe is 0, so all sixteen address outputs float.
- R4: Accesses to 0x0000 and 0x0001 never raise bus_strobe. Address 0x0002 is external.
- R5: Address 0x0000 is the direction register, readable and writable. A 1 in a bit makes that line an output, and this is seen on pin_oe.
- R6: Address 0x0001 is written into the output latch, which is seen on pin_out for all bits. A read of 0x0001 returns the latch bit for output lines and the pin level for input lines.
- R7: Register bit 5 has no pin. Pins 4..0 map to bits 4..0 and pins 6..5 map to bits 7..6. A read of bit 5 gives the latch bit when bit 5 is an output and 1 when it is an input.
- R8: While addr_en is 0, a pending request produces no strobe and no ready, and a port write does not change the registers. The request completes once addr_en returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr_en | input | 1 | 1: this block owns the bus; 0: address floated, requests stall |
| core_req | input | 1 | Core request, held until core_ready |
| core_we | input | 1 | Request is a write |
| core_addr | input | 16 | Request address |
| core_wdata | input | 8 | Write data |
| core_rdata | output | 8 | Read data, valid with core_ready |
| core_ready | output | 1 | One-cycle completion pulse |
| bus_addr | output | 16 | External address |
| bus_addr_oe | output | 1 | Address pad enable |
| bus_strobe | output | 1 | External cycle active |
| bus_rw | output | 1 | 1 read, 0 write |
| bus_dout | output | 8 | Data driven outward |
| bus_dout_oe | output | 1 | Data pad enable |
| bus_din | input | 8 | Data received from the bus |
| pin_in | input | 7 | Port pin levels |
| pin_out | output | 7 | Port output levels |
| pin_oe | output | 7 | Port pin output enables |

## Verification
The hardest state to reach is a request parked in HOLD, with the bus taken away from this block. The bench lowers addr_en before it issues a direction-register write. While the request stays pending, it checks that no ready and no strobe appear and that pin_oe keeps its old value. It then returns the enable and checks that the write lands. The unbonded bit is driven through both of its directions, with latch values 0 and 1, so that the constant-1 input reading can be told apart from the latch.

// File: rtl/bpi_pkg.sv
package bpi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_EXT,
        ST_PORT,
        ST_DONE
    } bpi_state_e;

    // Register bit index that drives external pin j when bit nc has no pin.
    function automatic int pin_to_bit(input int j, input int nc);
        return (j < nc) ? j : j + 1;
    endfunction

endpackage

// File: rtl/bpi_decode.sv
module bpi_decode #(
    parameter int AW       = 16,
    parameter int DIR_ADDR = 0,
    parameter int DAT_ADDR = 1
) (
    input  logic [AW-1:0] addr,
    output logic          hit_dir,
    output logic          hit_dat
);
    localparam logic [AW-1:0] DIR_A = AW'(DIR_ADDR);
    localparam logic [AW-1:0] DAT_A = AW'(DAT_ADDR);

    always_comb begin
        hit_dir = (addr == DIR_A);
        hit_dat = (addr == DAT_A);
    end
endmodule

// File: rtl/bpi_port.sv
module bpi_port #(
    parameter int DW     = 8,
    parameter int NC_BIT = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_dir,
    input  logic          wr_dat,
    input  logic [DW-1:0] wdata,
    input  logic          rd_dir,
    input  logic [DW-2:0] pin_in,
    output logic [DW-2:0] pin_out,
    output logic [DW-2:0] pin_oe,
    output logic [DW-1:0] rdata
);
    import bpi_pkg::*;

    logic [DW-1:0] dir_q;
    logic [DW-1:0] lat_q;
    logic [DW-1:0] view;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            lat_q <= '0;
        end else begin
            if (wr_dir) dir_q <= wdata;
            if (wr_dat) lat_q <= wdata;
        end
    end

    for (genvar i = 0; i < DW; i++) begin : g_view
        if (i == NC_BIT) begin : g_nc
            assign view[i] = dir_q[i] ? lat_q[i] : 1'b1;
        end else begin : g_pin
            localparam int PJ = (i < NC_BIT) ? i : i - 1;
            assign view[i] = dir_q[i] ? lat_q[i] : pin_in[PJ];
        end
    end

    for (genvar j = 0; j < DW - 1; j++) begin : g_pad
        localparam int BI = pin_to_bit(j, NC_BIT);
        assign pin_out[j] = lat_q[BI];
        assign pin_oe[j]  = dir_q[BI];
    end

    assign rdata = rd_dir ? dir_q : view;
endmodule

// File: rtl/bpi_seq.sv
module bpi_seq #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_en,
    input  logic          core_req,
    input  logic          core_we,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    input  logic          hit_dir,
    input  logic          hit_dat,
    input  logic [DW-1:0] bus_din,
    input  logic [DW-1:0] port_rdata,
    output logic [AW-1:0] req_addr,
    output logic [DW-1:0] req_wdata,
    output logic          req_we,
    output logic          req_dir,
    output logic          port_wr_dir,
    output logic          port_wr_dat,
    output logic          bus_strobe,
    output logic          bus_rw,
    output logic          bus_dout_oe,
    output logic          core_ready,
    output logic [DW-1:0] core_rdata
);
    import bpi_pkg::*;

    bpi_state_e st_q, st_d;
    logic       req_dat;
    logic       accept;
    logic       live;

    assign accept = (st_q == ST_IDLE) && core_req;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // request latch and read-data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_addr   <= '0;
            req_wdata  <= '0;
            req_we     <= 1'b0;
            req_dir    <= 1'b0;
            req_dat    <= 1'b0;
            core_rdata <= '0;
        end else begin
            if (accept) begin
                req_addr  <= core_addr;
                req_wdata <= core_wdata;
                req_we    <= core_we;
                req_dir   <= hit_dir;
                req_dat   <= hit_dat;
            end
            if (st_q == ST_EXT && addr_en)  core_rdata <= bus_din;
            if (st_q == ST_PORT && addr_en) core_rdata <= port_rdata;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (core_req) begin
                    if (!addr_en)                st_d = ST_HOLD;
                    else if (hit_dir || hit_dat) st_d = ST_PORT;
                    else                         st_d = ST_EXT;
                end
            end
            ST_HOLD: begin
                if (addr_en) st_d = (req_dir || req_dat) ? ST_PORT : ST_EXT;
            end
            ST_EXT:  st_d = addr_en ? ST_DONE : ST_HOLD;
            ST_PORT: st_d = addr_en ? ST_DONE : ST_HOLD;
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        live        = addr_en;
        bus_strobe  = 1'b0;
        port_wr_dir = 1'b0;
        port_wr_dat = 1'b0;
        core_ready  = 1'b0;
        unique case (st_q)
            ST_EXT:  bus_strobe = live;
            ST_PORT: begin
                port_wr_dir = live && req_we && req_dir;
                port_wr_dat = live && req_we && req_dat;
            end
            ST_DONE: core_ready = 1'b1;
            ST_IDLE, ST_HOLD: ;
            default: ;
        endcase
        bus_rw      = !req_we;
        bus_dout_oe = bus_strobe && req_we;
    end
endmodule

// File: rtl/bpi_top.sv
module bpi_top #(
    parameter int AW       = 16,
    parameter int DW       = 8,
    parameter int DIR_ADDR = 0,
    parameter int DAT_ADDR = 1,
    parameter int NC_BIT   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_en,
    input  logic          core_req,
    input  logic          core_we,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    output logic [DW-1:0] core_rdata,
    output logic          core_ready,
    output logic [AW-1:0] bus_addr,
    output logic          bus_addr_oe,
    output logic          bus_strobe,
    output logic          bus_rw,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dout_oe,
    input  logic [DW-1:0] bus_din,
    input  logic [DW-2:0] pin_in,
    output logic [DW-2:0] pin_out,
    output logic [DW-2:0] pin_oe
);
    logic          hit_dir, hit_dat;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          req_we, req_dir;
    logic          wr_dir, wr_dat;
    logic [DW-1:0] port_rdata;

    bpi_decode #(.AW(AW), .DIR_ADDR(DIR_ADDR), .DAT_ADDR(DAT_ADDR)) u_dec (
        .addr    (core_addr),
        .hit_dir (hit_dir),
        .hit_dat (hit_dat)
    );

    bpi_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_en     (addr_en),
        .core_req    (core_req),
        .core_we     (core_we),
        .core_addr   (core_addr),
        .core_wdata  (core_wdata),
        .hit_dir     (hit_dir),
        .hit_dat     (hit_dat),
        .bus_din     (bus_din),
        .port_rdata  (port_rdata),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_we      (req_we),
        .req_dir     (req_dir),
        .port_wr_dir (wr_dir),
        .port_wr_dat (wr_dat),
        .bus_strobe  (bus_strobe),
        .bus_rw      (bus_rw),
        .bus_dout_oe (bus_dout_oe),
        .core_ready  (core_ready),
        .core_rdata  (core_rdata)
    );

    bpi_port #(.DW(DW), .NC_BIT(NC_BIT)) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_dir  (wr_dir),
        .wr_dat  (wr_dat),
        .wdata   (req_wdata),
        .rd_dir  (req_dir),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .rdata   (port_rdata)
    );

    assign bus_addr    = req_addr;
    assign bus_addr_oe = addr_en;
    assign bus_dout    = req_wdata;
endmodule

// File: rtl/bpi_checker.sv
module bpi_checker #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          addr_en,
    input logic          bus_strobe,
    input logic          core_ready,
    input logic [AW-1:0] bus_addr,
    input logic [DW-2:0] pin_oe,
    input logic [DW-2:0] pin_out
);
    AST_FLOAT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_en |-> !bus_strobe); // R8

    AST_PORT_STAYS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |-> (bus_addr[AW-1:1] != '0)); // R4

    AST_STROBE_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |=> core_ready); // R2

    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_ready |=> !core_ready); // R2

    AST_DIR_FROZEN_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_en |=> $stable(pin_oe)); // R8

    AST_LATCH_FROZEN_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_en |=> $stable(pin_out)); // R8
endmodule

bind bpi_top bpi_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_en    (addr_en),
    .bus_strobe (bus_strobe),
    .core_ready (core_ready),
    .bus_addr   (bus_addr),
    .pin_oe     (pin_oe),
    .pin_out    (pin_out)
);

// File: tb/sim_bpi_top.sv
module sim_bpi_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_en = 1'b1;
    logic        core_req = 1'b0;
    logic        core_we = 1'b0;
    logic [15:0] core_addr = '0;
    logic [7:0]  core_wdata = '0;
    logic [7:0]  core_rdata;
    logic        core_ready;
    logic [15:0] bus_addr;
    logic        bus_addr_oe;
    logic        bus_strobe;
    logic        bus_rw;
    logic [7:0]  bus_dout;
    logic        bus_dout_oe;
    logic [7:0]  bus_din;
    logic [6:0]  pin_in = '0;
    logic [6:0]  pin_out;
    logic [6:0]  pin_oe;

    int total = 0;
    int bad = 0;
    int ready_cnt = 0;
    int strobe_cnt = 0;
    int cycles = 0;
    bit finished = 0;

    logic [7:0] m_dir = 8'h00;
    logic [7:0] m_lat = 8'h00;

    // scoreboard items: {addr, rw, wdata} and {check, data}
    logic [24:0] exp_ext[$];
    logic [8:0]  exp_rd[$];

    always #2 clk = ~clk;

    bpi_top u0 (.*);

    function automatic logic [7:0] mem_val(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction
    assign bus_din = mem_val(bus_addr);

    function automatic logic [6:0] squeeze(input logic [7:0] v);
        return {v[7:6], v[4:0]};
    endfunction

    function automatic logic [7:0] port_view(input logic [7:0] d, input logic [7:0] l,
                                              input logic [6:0] p);
        logic [7:0] pins8;
        pins8 = {p[6:5], 1'b1, p[4:0]};
        return (d & l) | (~d & pins8);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // monitor: pops expectations as the design produces results
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (bus_strobe) begin
                strobe_cnt++;
                if (!addr_en) chk(1'b0, "R8 strobe while floated", 32'(bus_strobe), 32'd0);
                if (exp_ext.size() == 0) begin
                    chk(1'b0, "R4 unexpected strobe", 32'(bus_addr), 32'd0);
                end else begin
                    logic [24:0] e;
                    e = exp_ext.pop_front();
                    chk(bus_addr == e[24:9], "R2 bus_addr", 32'(bus_addr), 32'(e[24:9]));
                    chk(bus_rw == e[8], "R2 bus_rw", 32'(bus_rw), 32'(e[8]));
                    chk(bus_dout_oe == !e[8], "R2 bus_dout_oe", 32'(bus_dout_oe), 32'(!e[8]));
                    if (!e[8]) chk(bus_dout == e[7:0], "R2 bus_dout", 32'(bus_dout), 32'(e[7:0]));
                end
            end
            if (core_ready) begin
                ready_cnt++;
                if (exp_rd.size() == 0) begin
                    chk(1'b0, "R2 unexpected ready", 32'(core_rdata), 32'd0);
                end else begin
                    logic [8:0] r;
                    r = exp_rd.pop_front();
                    if (r[8]) chk(core_rdata == r[7:0], "R2/R5/R6/R7 rdata",
                                  32'(core_rdata), 32'(r[7:0]));
                end
            end
        end
    end

    // driver: pushes expectations, then runs one request
    task automatic access(input logic [15:0] a, input bit we, input logic [7:0] wd);
        if (a > 16'd1) begin
            exp_ext.push_back({a, !we, wd});
            exp_rd.push_back({!we, mem_val(a)});
        end else if (a == 16'd0) begin
            exp_rd.push_back({!we, m_dir});
            if (we) m_dir = wd;
        end else begin
            exp_rd.push_back({!we, port_view(m_dir, m_lat, pin_in)});
            if (we) m_lat = wd;
        end
        @(negedge clk);
        core_req = 1'b1; core_we = we; core_addr = a; core_wdata = wd;
        do @(negedge clk); while (!core_ready);
        core_req = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pin_oe == 7'h00, "R1 pin_oe", 32'(pin_oe), 32'h0);
        chk(pin_out == 7'h00, "R1 pin_out", 32'(pin_out), 32'h0);
        chk(core_ready == 1'b0, "R1 core_ready", 32'(core_ready), 32'h0);
        chk(bus_strobe == 1'b0, "R1 bus_strobe", 32'(bus_strobe), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1/R7 reset read of data address: bit 5 input reads 1
        access(16'h0001, 0, 8'h00);
        access(16'h0000, 0, 8'h00);

        // R2 external cycles
        access(16'h1234, 1, 8'h3C);
        access(16'hABCD, 0, 8'h00);
        access(16'hFFFF, 0, 8'h00);
        // R4 boundary: 0x0002 goes external, 0x0000/0x0001 do not
        begin
            int s0;
            s0 = strobe_cnt;
            access(16'h0002, 0, 8'h00);
            chk(strobe_cnt == s0 + 1, "R4 0x0002 external", 32'(strobe_cnt - s0), 32'd1);
            s0 = strobe_cnt;
            access(16'h0000, 1, 8'hA5);
            access(16'h0001, 1, 8'h5A);
            chk(strobe_cnt == s0, "R4 port no strobe", 32'(strobe_cnt - s0), 32'd0);
        end
        // R5 direction on pins
        chk(pin_oe == squeeze(8'hA5), "R5 pin_oe", 32'(pin_oe), 32'(squeeze(8'hA5)));
        chk(pin_out == squeeze(8'h5A), "R6 pin_out", 32'(pin_out), 32'(squeeze(8'h5A)));
        access(16'h0000, 0, 8'h00);
        // R6 mixed read
        pin_in = 7'h33;
        access(16'h0001, 0, 8'h00);
        pin_in = 7'h4C;
        access(16'h0001, 0, 8'h00);
        // R7 unbonded bit in both directions
        access(16'h0000, 1, 8'h20);
        access(16'h0001, 1, 8'h20);
        access(16'h0001, 0, 8'h00);
        access(16'h0001, 1, 8'h00);
        access(16'h0001, 0, 8'h00);
        access(16'h0000, 1, 8'hDF);
        pin_in = 7'h00;
        access(16'h0001, 0, 8'h00);

        // R3 / R8 floated bus
        @(negedge clk);
        addr_en = 1'b0;
        @(negedge clk);
        chk(bus_addr_oe == 1'b0, "R3 address floated", 32'(bus_addr_oe), 32'd0);
        begin
            int r0, s0;
            logic [6:0] oe0;
            r0 = ready_cnt; s0 = strobe_cnt; oe0 = pin_oe;
            fork
                access(16'h0000, 1, 8'h0F);
                begin
                    repeat (6) @(negedge clk);
                    chk(ready_cnt == r0, "R8 no ready while floated", 32'(ready_cnt - r0), 32'd0);
                    chk(pin_oe == oe0, "R8 dir unchanged while floated", 32'(pin_oe), 32'(oe0));
                    addr_en = 1'b1;
                end
            join
            chk(pin_oe == squeeze(8'h0F), "R8 write lands after release",
                32'(pin_oe), 32'(squeeze(8'h0F)));
            chk(bus_addr_oe == 1'b1, "R3 address driven", 32'(bus_addr_oe), 32'd1);
            // stalled external read
            addr_en = 1'b0;
            fork
                access(16'h4321, 0, 8'h00);
                begin
                    repeat (5) @(negedge clk);
                    chk(strobe_cnt == s0, "R8 no strobe while floated",
                        32'(strobe_cnt - s0), 32'd0);
                    addr_en = 1'b1;
                end
            join
            chk(strobe_cnt == s0 + 1, "R8 external completes", 32'(strobe_cnt - s0), 32'd1);
        end
        access(16'h0000, 0, 8'h00);

        repeat (3) @(negedge clk);
        chk(exp_ext.size() == 0, "R2 ext queue drained", 32'(exp_ext.size()), 32'd0);
        chk(exp_rd.size() == 0, "R2 ready queue drained", 32'(exp_rd.size()), 32'd0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule